// File: doc/BRIEF.md
# Converter Protection and Enable Supervisor

This block is the supervisory state machine that decides whether a bridge converter's PWM stage may switch. It takes digital flags in place of the analog circuits: a supply-good flag from the undervoltage detector, a latching shutdown request, a non-latching on/off enable, a peak-current trip flag and a soft-start done flag. It returns a gate-drive enable, a sync-output enable, a low-power indication and a soft-start reset request that holds the external soft-start ramp at zero.

A latching shutdown forces the block into a latched-off, low-power state from any state, including the power-up wait. Only the power-on reset clears it. The on/off input, the supply flag and the shutdown input returning low have no effect on it. A peak-current trip does not merely clip one cycle. It restarts the converter through a full soft-start. The latching shutdown input is asynchronous and passes through a synchronizer. All other inputs are treated as synchronous to the clock.

Top module: `conv_guard`

## Requirements
- R1: While and directly after rst_ni is low, the block is in the power-up wait state: drive_en_o=0, sync_en_o=0, low_power_o=0, ss_reset_o=1.
- R2: In any state other than latched-off, supply_ok_i=0 at a clock edge sends the block to the power-up wait state, with drive_en_o=0 and sync_en_o=0 from the following cycle on.
- R3: latch_sd_i passes through a two-stage synchronizer. A high level sampled at edge e makes low_power_o=1 after edge e+2. This holds from every state, including the power-up wait with supply_ok_i=0.
- R4: In the latched-off state, drive_en_o=0, sync_en_o=0, ss_reset_o=1 and low_power_o=1. Only rst_ni leaves that state. on_i, supply_ok_i and latch_sd_i returning low do not.
- R5: When not latched and supply_ok_i=1, on_i=0 at an edge sends the block to the off state: drive_en_o=0, sync_en_o=0, ss_reset_o=1, low_power_o=0.
- R6: Power-up wait goes to off on the first edge with supply_ok_i=1. Off goes to soft-start on the first edge with supply_ok_i=1 and on_i=1.
- R7: In soft-start (outside a restart cycle), drive_en_o=1, sync_en_o=0 and ss_reset_o=0. ss_done_i=1 at an edge moves the block to run.
- R8: In run, drive_en_o=1, sync_en_o=1 and ss_reset_o=0. sync_en_o=1 never occurs without drive_en_o=1.
- R9: peak_fault_i=1 at an edge while in soft-start or run, with supply_ok_i=1 and on_i=1, gives one restart cycle in soft-start. In that cycle drive_en_o=0, sync_en_o=0 and ss_reset_o=1, and ss_done_i is ignored at the edge that ends it. Soft-start then proceeds as in R7.
- R10: Priority at each edge, from highest to lowest: latched shutdown, supply low, on low, peak fault, soft-start done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| supply_ok_i | input | 1 | Supply above turn-on threshold |
| latch_sd_i | input | 1 | Latching shutdown request, asynchronous |
| on_i | input | 1 | Non-latching enable |
| peak_fault_i | input | 1 | Peak-current trip |
| ss_done_i | input | 1 | Soft-start ramp complete |
| drive_en_o | output | 1 | Gate-drive enable |
| sync_en_o | output | 1 | Sync-output enable |
| low_power_o | output | 1 | Latched-off, low-power indication |
| ss_reset_o | output | 1 | Hold or restart soft-start |

## Verification
The bench targets the stickiness of the latch. A design that let on/off or the supply flag clear it would turn drive back on, and the bench catches this after toggling both. It also measures the synchronizer latency exactly. A design with one stage too few or too many shows low_power_o one cycle early or late. A long pseudo-random sweep of the other four inputs is compared against an arithmetic model of the priorities. That sweep exposes a swapped priority, a peak fault that fails to drop drive for its restart cycle, or a done flag honoured during the restart cycle, because each produces a wrong output vector in some cycle.

// File: rtl/conv_guard_pkg.sv
package conv_guard_pkg;
  typedef enum logic [2:0] {
    ST_POR_WAIT = 3'd0,
    ST_OFF      = 3'd1,
    ST_SOFT     = 3'd2,
    ST_RUN      = 3'd3,
    ST_LATCHED  = 3'd4
  } guard_state_e;
endpackage

// File: rtl/conv_guard_sync.sv
module conv_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/conv_guard_fsm.sv
module conv_guard_fsm
  import conv_guard_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sd_sync_i,
  input  logic         supply_ok_i,
  input  logic         on_i,
  input  logic         peak_fault_i,
  input  logic         ss_done_i,
  output guard_state_e state_o,
  output logic         restart_o
);
  guard_state_e state_q, state_d;
  logic         restart_q, restart_d;
  logic         active;

  assign active = (state_q == ST_SOFT) || (state_q == ST_RUN);

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    if (sd_sync_i || state_q == ST_LATCHED) begin
      state_d = ST_LATCHED;           // latch dominates everything
    end else if (!supply_ok_i) begin
      state_d = ST_POR_WAIT;
    end else if (!on_i) begin
      state_d = ST_OFF;
    end else if (active && peak_fault_i) begin
      state_d   = ST_SOFT;
      restart_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_POR_WAIT: state_d = ST_OFF;
        ST_OFF:      state_d = ST_SOFT;
        ST_SOFT:     if (ss_done_i && !restart_q) state_d = ST_RUN;
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_POR_WAIT;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
    end
  end

  assign state_o   = state_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/conv_guard_outdec.sv
module conv_guard_outdec
  import conv_guard_pkg::*;
(
  input  guard_state_e state_i,
  input  logic         restart_i,
  output logic         drive_en_o,
  output logic         sync_en_o,
  output logic         low_power_o,
  output logic         ss_reset_o
);
  logic active;
  assign active      = (state_i == ST_SOFT) || (state_i == ST_RUN);
  assign drive_en_o  = active && !restart_i;
  assign sync_en_o   = (state_i == ST_RUN);
  assign low_power_o = (state_i == ST_LATCHED);
  assign ss_reset_o  = !active || restart_i;
endmodule

// File: rtl/conv_guard.sv
module conv_guard
  import conv_guard_pkg::*;
#(
  parameter int SD_SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic latch_sd_i,
  input  logic on_i,
  input  logic peak_fault_i,
  input  logic ss_done_i,
  output logic drive_en_o,
  output logic sync_en_o,
  output logic low_power_o,
  output logic ss_reset_o
);
  logic         sd_sync;
  guard_state_e state;
  logic         restart;

  conv_guard_sync #(.STAGES(SD_SYNC_STAGES)) u_sd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (latch_sd_i),
    .q_o   (sd_sync)
  );

  conv_guard_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sd_sync_i   (sd_sync),
    .supply_ok_i (supply_ok_i),
    .on_i        (on_i),
    .peak_fault_i(peak_fault_i),
    .ss_done_i   (ss_done_i),
    .state_o     (state),
    .restart_o   (restart)
  );

  conv_guard_outdec u_dec (
    .state_i    (state),
    .restart_i  (restart),
    .drive_en_o (drive_en_o),
    .sync_en_o  (sync_en_o),
    .low_power_o(low_power_o),
    .ss_reset_o (ss_reset_o)
  );
endmodule

// File: rtl/conv_guard_chk.sv
module conv_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic latch_sd_i,
  input logic on_i,
  input logic peak_fault_i,
  input logic ss_done_i,
  input logic drive_en_o,
  input logic sync_en_o,
  input logic low_power_o,
  input logic ss_reset_o
);
  AST_LATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_o |=> low_power_o); // R4
  AST_LATCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_o |-> (!drive_en_o && !sync_en_o && ss_reset_o)); // R4
  AST_SUPPLY_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!drive_en_o && !sync_en_o)); // R2
  AST_ON_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |=> (!drive_en_o && !sync_en_o && ss_reset_o)); // R5
  AST_PEAK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && peak_fault_i) |=> (!drive_en_o && !sync_en_o && ss_reset_o)); // R9
  AST_SYNC_NEEDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_o |-> drive_en_o); // R8
  AST_SD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(latch_sd_i, 3) && $past(rst_ni, 1) && $past(rst_ni, 2) && $past(rst_ni, 3))
      |-> low_power_o); // R3
endmodule

bind conv_guard conv_guard_chk u_chk (.*);

// File: tb/tb_conv_guard.sv
`timescale 1ns/1ps
module tb_conv_guard;
  localparam int M_POR = 0, M_OFF = 1, M_SOFT = 2, M_RUN = 3, M_LAT = 4;

  logic clk = 1'b0;
  logic rst_ni, supply_ok, latch_sd, on, peak, done;
  logic drive_en, sync_en, low_power, ss_reset;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  conv_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .latch_sd_i(latch_sd),
    .on_i(on), .peak_fault_i(peak), .ss_done_i(done),
    .drive_en_o(drive_en), .sync_en_o(sync_en), .low_power_o(low_power), .ss_reset_o(ss_reset)
  );

  // {drive, sync, low_power, ss_reset}
  function automatic logic [3:0] exp_out(int st, bit rs);
    case (st)
      M_SOFT:  return rs ? 4'b0001 : 4'b1000;
      M_RUN:   return 4'b1100;
      M_LAT:   return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic string tag_of(int st, bit rs);
    case (st)
      M_POR:   return "R2";
      M_OFF:   return "R5";
      M_SOFT:  return rs ? "R9" : "R7";
      M_RUN:   return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {drive_en, sync_en, low_power, ss_reset};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: outputs=hung expected=done");
    finish_run();
  end

  initial begin
    int st;
    bit rs;
    int unsigned lcg;
    rst_ni = 1'b0; supply_ok = 0; latch_sd = 0; on = 0; peak = 0; done = 0;
    step(2);
    check("R1", 4'b0001);             // in reset
    rst_ni = 1'b1;
    step(1);
    check("R1", 4'b0001);             // supply still low

    // R6 bring-up path then R7, R8
    supply_ok = 1; on = 1;
    step(1); check("R6", 4'b0001);    // off
    step(1); check("R6", 4'b1000);    // soft-start
    step(3); check("R7", 4'b1000);    // done low keeps soft-start
    done = 1;
    step(1); check("R8", 4'b1100);
    // R10: on low beats peak fault
    on = 0; peak = 1;
    step(1); check("R10", 4'b0001);
    on = 1; peak = 0; done = 0;
    step(2); check("R10", 4'b1000);

    // Pseudo-random sweep of supply/on/peak/done vs arithmetic model (sd=0)
    st = M_SOFT; rs = 1'b0; lcg = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      int nst;
      bit nrs;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      supply_ok = (lcg[27:24] != 4'd0);
      on        = (lcg[22:20] != 3'd0);
      peak      = (lcg[18:16] == 3'd0);
      done      = lcg[12];
      nrs = 1'b0;
      if (!supply_ok) nst = M_POR;
      else if (!on) nst = M_OFF;
      else if ((st == M_SOFT || st == M_RUN) && peak) begin nst = M_SOFT; nrs = 1'b1; end
      else if (st == M_POR) nst = M_OFF;
      else if (st == M_OFF) nst = M_SOFT;
      else if (st == M_SOFT && done && !rs) nst = M_RUN;
      else nst = st;
      step(1);
      st = nst; rs = nrs;
      check(tag_of(st, rs), exp_out(st, rs));
    end

    // R3 latency from run
    supply_ok = 1; on = 1; peak = 0; done = 1;
    step(4); check("R8", 4'b1100);
    latch_sd = 1;
    step(2); check("R3", 4'b1100);    // two sync stages, not yet latched
    step(1); check("R3", 4'b0011);
    // R4: nothing but reset clears the latch
    latch_sd = 0; on = 0; step(2); on = 1; step(2);
    supply_ok = 0; step(2); supply_ok = 1; step(3);
    check("R4", 4'b0011);

    // R3 from power-up wait
    rst_ni = 0; step(1); check("R1", 4'b0001);
    rst_ni = 1; supply_ok = 0; on = 0;
    step(1); check("R1", 4'b0001);
    latch_sd = 1; step(1); latch_sd = 0;
    step(1); check("R3", 4'b0001);
    step(1); check("R3", 4'b0011);
    supply_ok = 1; on = 1; done = 1; step(5);
    check("R4", 4'b0011);
    rst_ni = 0; step(1); rst_ni = 1;
    step(1); check("R6", 4'b0001);

    finish_run();
  end
endmodule